// File: doc/BRIEF.md
# Interrupt Bid Arbiter

This block decides which of eighteen interrupt sources of a multi-channel serial controller gets served, and whether the processor is interrupted at all. Each requesting source presents a numeric bid. The bid packs together a software-programmed priority level, the channel the source belongs to and the kind of source. The arbiter keeps picking the largest bid. It drives an active-low level interrupt while that bid is strictly larger than a programmable threshold, so software can raise the threshold to mask whole classes of low-importance events.

When the processor acknowledges, the block latches the current winning bid into a current-interrupt register. It then presents an interrupt vector on its output. That vector is either a fixed base value, or the base value with its low bits replaced by the winner's channel and source kind, so that a handler can be reached without further decoding. The bidding can run every clock, or every second clock for slower comparison timing.

Top module: `irq_bid_arbiter`

## Requirements
- R1: Source i has kind i/4 and channel i%4. Its bid is the 8-bit code {priority[2:0], channel[1:0], kind[2:0]}, that is priority*32 + channel*8 + kind, where priority is bits 3i+2..3i of the priority input.
- R2: The winning bid is the largest bid among all sources. When bids are equal, the lower source index wins.
- R3: In full-rate mode the interrupt output is low one cycle after the inputs settle exactly when the winning bid is strictly greater than the threshold. A winning bid equal to the threshold leaves the output high.
- R4: A source that is not requesting bids zero. With no source requesting, the interrupt output stays high for every threshold value.
- R5: With half-rate mode set, the winner and the interrupt output update only on every second clock edge. With it clear, they update on every edge.
- R6: An acknowledge pulse sampled at a clock edge loads the current-interrupt register with the winning bid that was registered before that edge.
- R7: Without an acknowledge, the current-interrupt register keeps its value, even when the winner changes.
- R8: With vector mode clear, the vector output equals the base vector. With it set, the vector output is {base[7:5], channel, kind} of the current-interrupt register.
- R9: After reset, the interrupt output is high and the current-interrupt register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 18 | Request line per source |
| prio_i | input | 54 | 3-bit priority per source, source i at bits 3i+2..3i |
| thresh_i | input | 8 | Interrupt threshold |
| half_rate_i | input | 1 | Evaluate bids every second clock |
| ack_i | input | 1 | Acknowledge strobe, captures the winner |
| vec_mod_i | input | 1 | Select the modified vector |
| base_vec_i | input | 8 | Base interrupt vector |
| irq_n_o | output | 1 | Interrupt request, active low level |
| cir_o | output | 8 | Current-interrupt register |
| vec_o | output | 8 | Interrupt vector |

## Verification
Random request sets with random priorities and thresholds test the maximum search. Many of them have several sources requesting at once, so a search that keeps the first or the last requester gets a different code than one that keeps the largest. Directed cases set the threshold equal to the winning bid and one below it, which separates a strict from a non-strict comparison. They also drop every request while the threshold is zero, which shows whether idle sources really bid zero. A request pattern that toggles every cycle tells the half-rate mode from full rate by counting how often the interrupt output changes. Acknowledges are spaced with winner changes in between, so the tests can tell a register that holds its value from one that follows the winner.

// File: rtl/irq_bid_arbiter.sv
module irq_bid_arbiter #(
  parameter int NSRC   = 18,
  parameter int PRIO_W = 3,
  parameter int CH_W   = 2,
  parameter int KIND_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0]          req_i,
  input  logic [NSRC*PRIO_W-1:0]   prio_i,
  input  logic [PRIO_W+CH_W+KIND_W-1:0] thresh_i,
  input  logic                     half_rate_i,
  input  logic                     ack_i,
  input  logic                     vec_mod_i,
  input  logic [PRIO_W+CH_W+KIND_W-1:0] base_vec_i,
  output logic                     irq_n_o,
  output logic [PRIO_W+CH_W+KIND_W-1:0] cir_o,
  output logic [PRIO_W+CH_W+KIND_W-1:0] vec_o
);
  localparam int CODE_W = PRIO_W + CH_W + KIND_W;
  localparam int LOW_W  = CH_W + KIND_W;

  logic [CODE_W-1:0] bid   [NSRC];
  logic [CODE_W-1:0] best;
  logic [CODE_W-1:0] win_q, cir_q;
  logic              irq_q, phase_q;
  logic              eval;

  for (genvar i = 0; i < NSRC; i++) begin : g_bid
    localparam logic [CH_W-1:0]   CH   = CH_W'(i % (1 << CH_W));
    localparam logic [KIND_W-1:0] KIND = KIND_W'(i / (1 << CH_W));
    assign bid[i] = req_i[i] ? {prio_i[i*PRIO_W +: PRIO_W], CH, KIND} : '0;
  end

  always_comb begin
    best = '0;
    for (int i = 0; i < NSRC; i++)
      if (bid[i] > best) best = bid[i];
  end

  assign eval = !half_rate_i || phase_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase_q <= 1'b0;
      win_q   <= '0;
      irq_q   <= 1'b0;
      cir_q   <= '0;
    end else begin
      phase_q <= !phase_q;
      if (eval) begin
        win_q <= best;
        irq_q <= best > thresh_i;
      end
      if (ack_i) cir_q <= win_q;
    end

  assign irq_n_o = !irq_q;
  assign cir_o   = cir_q;
  assign vec_o   = vec_mod_i ? {base_vec_i[CODE_W-1:LOW_W], cir_q[LOW_W-1:0]} : base_vec_i;

  assert_strict_cmp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eval |=> (irq_n_o == !(win_q > $past(thresh_i))));
  assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && req_i == '0) |=> (win_q == '0 && irq_n_o));
  assert_half_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (half_rate_i && !phase_q) |=> ($stable(win_q) && $stable(irq_n_o)));
  assert_ack_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> (cir_o == $past(win_q)));
  assert_cir_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> $stable(cir_o));
endmodule

// File: tb/sim_irq_bid_arbiter.sv
module sim_irq_bid_arbiter;
  localparam int N = 18;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] req = '0;
  logic [3*N-1:0] prio = '0;
  logic [7:0] thr = '0, base = 8'hA0;
  logic half = 0, ack = 0, vmod = 0;
  logic irq_n;
  logic [7:0] cir, vec;
  int vecs = 0, bad = 0;

  irq_bid_arbiter u0 (.clk(clk), .rst_n(rst_n), .req_i(req), .prio_i(prio),
    .thresh_i(thr), .half_rate_i(half), .ack_i(ack), .vec_mod_i(vmod),
    .base_vec_i(base), .irq_n_o(irq_n), .cir_o(cir), .vec_o(vec));

  always #10 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  function automatic logic [7:0] exp_max(logic [N-1:0] r, logic [3*N-1:0] p);
    logic [7:0] m = 0;
    for (int i = 0; i < N; i++) begin
      logic [7:0] c = {p[3*i +: 3], 2'(i % 4), 3'(i / 4)};
      if (r[i] && c > m) m = c;
    end
    return m;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  task automatic do_ack;
    ack = 1; cyc(1); ack = 0;
  endtask

  initial begin
    logic [7:0] m;
    int tr;
    logic last;
    void'($urandom(32'h5EED));
    cyc(2);
    chk("R9 irq_n reset", irq_n, 1);
    chk("R9 cir reset", cir, 0);
    chk("R8 vec plain", vec, 8'hA0);
    rst_n = 1; cyc(1);

    // R1 single source 13: kind 3, channel 1, priority 5
    req = 18'(1) << 13; prio[39 +: 3] = 3'd5; thr = 0; cyc(2); do_ack;
    chk("R1 bid code src13", cir, {3'd5, 2'd1, 3'd3});
    vmod = 1; #1;
    chk("R8 modified vec", vec, {3'b101, 2'd1, 3'd3});
    vmod = 0; #1;
    chk("R8 plain vec", vec, 8'hA0);

    // R3 threshold equal vs one below
    thr = {3'd5, 2'd1, 3'd3}; cyc(2);
    chk("R3 equal masks", irq_n, 1);
    thr = thr - 1; cyc(2);
    chk("R3 above fires", irq_n, 0);

    // R4 no request, threshold zero
    req = '0; thr = 0; cyc(2);
    chk("R4 idle irq_n", irq_n, 1);

    // R2 max of two with same priority: higher channel/kind wins
    prio = '0; req = 18'b11; cyc(2); do_ack;
    chk("R2 max of two", cir, {3'd0, 2'd1, 3'd0});

    // R7 hold when winner changes without ack
    req = 18'(1) << 17; prio[51 +: 3] = 3'd7; cyc(3);
    chk("R7 cir held", cir, {3'd0, 2'd1, 3'd0});
    do_ack;
    chk("R6 ack loads new winner", cir, {3'd7, 2'd1, 3'd4});

    // R5 full vs half rate with a toggling request
    prio = '0; prio[51 +: 3] = 3'd7; thr = 0;
    tr = 0; last = irq_n;
    for (int k = 0; k < 20; k++) begin
      req = (k % 2) ? '0 : (18'(1) << 17); cyc(1);
      if (irq_n != last) tr++; last = irq_n;
    end
    chk("R5 full rate follows", tr >= 15, 1);
    half = 1; cyc(2);
    tr = 0; last = irq_n;
    for (int k = 0; k < 20; k++) begin
      req = (k % 2) ? '0 : (18'(1) << 17); cyc(1);
      if (irq_n != last) tr++; last = irq_n;
    end
    chk("R5 half rate decimates", tr <= 1, 1);
    half = 0; req = '0; cyc(2);

    // random mix
    for (int k = 0; k < 300; k++) begin
      req = 18'($urandom); if (k % 5 == 0) req = req & 18'($urandom);
      prio = {22'($urandom), 32'($urandom)};
      thr = 8'($urandom); base = 8'($urandom); vmod = 1'($urandom);
      m = exp_max(req, prio);
      cyc(2);
      chk("R3 random irq", irq_n, !(m > thr));
      do_ack;
      chk("R2 R6 random cir", cir, m);
      chk("R8 random vec", vec, vmod ? {base[7:5], m[4:0]} : base);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule